// File: doc/BRIEF.md
# Relay Power-Save Sequencer

This block supervises the drive state of a bank of relay channels. Each channel is either off, at full drive (just switched on, still pulling in), or at reduced hold drive (already closed, kept closed at lower current). A host commits a new on/off vector through a write port. Every commit restarts a pull-in delay counter. When that counter runs out, every channel that is on drops to hold drive. A channel already at hold drive keeps it across later writes that leave it on.

An external power-save level can force the drop to hold at any time. Keeping that level low for long enough after the last commit cancels hold drive everywhere. A configuration code selects the hold current; code 000 turns the feature off. A fixed-level build ignores the configuration and always holds at 60 %. Two thermal inputs act on the bank: a warning level cancels hold drive, and a trip level switches every channel off.

The write port is valid/ready. A vector is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops while `thermal_trip` is high, so a pending vector waits, unchanged, until the trip clears. The sender must hold `wr_valid` and `wr_data` steady until the vector is accepted.

Top module: `relay_ps_seq`

## Requirements
- R1: After reset every channel is off, the configuration code reads 000, `hold_pct` reads 100 and `wr_ready` is high.
- R2: `hold_code` reports the stored configuration code. For a code c from 1 to 7, `hold_pct` is 20+10*c, so 001 gives 30 and 111 gives 90. For code 000, `hold_pct` is 100. With FIXED_LEVEL=1, `hold_code` is always 100 and `hold_pct` is always 60, and configuration writes have no effect.
- R3: Channel i reports its state on `ch_mode[2i+1:2i]`: 00 means off, 01 full drive, 10 hold drive. The value 11 never appears.
- R4: An accepted write with bit i of `wr_data` at 0 puts channel i in the off state at the same clock edge.
- R5: An accepted write with bit i at 1 moves an off channel i to full drive at that edge, even while `ps_force` is high.
- R6: An accepted write with bit i at 1 leaves channel i unchanged if it is already at full drive or at hold drive.
- R7: Exactly DELAY_CYCLES clock edges after the most recent accepted write, every full-drive channel moves to hold drive. Each new write restarts the count.
- R8: While `ps_force` is high, at each clock edge with no accepted write, every full-drive channel moves to hold drive.
- R9: When `ps_force` has been low for MIN_LOW_CYCLES consecutive edges, all counted since the most recent write, every hold-drive channel returns to full drive and any pending delay is cancelled.
- R10: While the code is 000 or `thermal_warn` is high, every hold-drive channel returns to full drive at the next edge, and no channel enters hold drive.
- R11: While `thermal_trip` is high, every channel is off from the next edge on, `wr_ready` is low and a pending write is held until the trip clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | On/off vector offered |
| wr_ready | output | 1 | Vector can be taken (low during thermal trip) |
| wr_data | input | N_CH | On/off vector, bit i for channel i, 1 = on |
| cfg_we | input | 1 | Configuration code write strobe |
| cfg_code | input | 3 | New hold-level code |
| ps_force | input | 1 | External power-save level |
| thermal_warn | input | 1 | Cancels and blocks hold drive |
| thermal_trip | input | 1 | Forces all channels off |
| ch_mode | output | 2*N_CH | Per-channel state, 2 bits each |
| hold_code | output | 3 | Active hold-level code |
| hold_pct | output | 7 | Hold current in percent of nominal |

## Verification
The bench attacks timing at both ends of the delay. It checks one edge before and one edge after expiry, and it sends a second write just before expiry. A design that did not restart the counter would drop to hold drive too early, and an off-by-one counter would miss by an edge. Stickiness is swept over all 256 write vectors, each applied on top of the previous vector's hold-drive set while forcing is held high. A design that reset held channels on rewrite, or dropped newly switched channels straight to hold, would miscompare there. The minimum-low window, the warning and code-000 cancellation, the trip with a stalled write that lands after release, and the fixed-level build are each checked on the exact edge where they take effect.

// File: rtl/relay_ps_pkg.sv
`timescale 1ns/1ps
package relay_ps_pkg;
  localparam int CODE_W = 3;
  localparam int PCT_W  = 7;

  typedef enum logic [1:0] {
    CH_OFF  = 2'b00,
    CH_FULL = 2'b01,
    CH_HOLD = 2'b10
  } ch_mode_e;

  function automatic logic [PCT_W-1:0] pct_of(input logic [CODE_W-1:0] code);
    if (code == '0) return PCT_W'(100);
    return PCT_W'(20 + 10 * int'(code));
  endfunction
endpackage

// File: rtl/relay_ps_delay.sv
`timescale 1ns/1ps
module relay_ps_delay #(
  parameter int DELAY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cancel,
  output logic expire
);
  localparam int W = $clog2(DELAY_CYCLES + 1);
  localparam logic [W-1:0] LOAD = W'(DELAY_CYCLES);
  localparam logic [W-1:0] LAST = W'(1);

  logic [W-1:0] cnt;
  logic         run;

  assign expire = run && (cnt == LAST) && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (restart) begin
      cnt <= LOAD;
      run <= 1'b1;
    end else if (cancel || expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - LAST;
    end
  end
endmodule

// File: rtl/relay_ps_lowwatch.sv
`timescale 1ns/1ps
module relay_ps_lowwatch #(
  parameter int MIN_LOW_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic level,
  output logic fire
);
  localparam int W = $clog2(MIN_LOW_CYCLES + 1);
  localparam logic [W-1:0] LIM  = W'(MIN_LOW_CYCLES);
  localparam logic [W-1:0] PRE  = W'(MIN_LOW_CYCLES - 1);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt;

  assign fire = !clear && !level && (cnt == PRE);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || level) cnt <= '0;
    else if (cnt != LIM)          cnt <= cnt + STEP;
  end
endmodule

// File: rtl/relay_ps_chan.sv
`timescale 1ns/1ps
module relay_ps_chan
  import relay_ps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       wr_bit,
  input  logic       trip,
  input  logic       revert,
  input  logic       reduce,
  output logic [1:0] mode
);
  ch_mode_e cur, nxt;

  always_comb begin
    nxt = cur;
    if (wr_fire) nxt = !wr_bit ? CH_OFF : ((cur == CH_OFF) ? CH_FULL : cur);
    if (revert && nxt == CH_HOLD) nxt = CH_FULL;
    if (reduce && nxt == CH_FULL) nxt = CH_HOLD;
    if (trip) nxt = CH_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= CH_OFF;
    else        cur <= nxt;
  end

  assign mode = cur;
endmodule

// File: rtl/relay_ps_seq.sv
`timescale 1ns/1ps
module relay_ps_seq
  import relay_ps_pkg::*;
#(
  parameter int N_CH           = 8,
  parameter int DELAY_CYCLES   = 1000,
  parameter int MIN_LOW_CYCLES = 3000,
  parameter bit FIXED_LEVEL    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [N_CH-1:0]     wr_data,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_code,
  input  logic                ps_force,
  input  logic                thermal_warn,
  input  logic                thermal_trip,
  output logic [2*N_CH-1:0]   ch_mode,
  output logic [2:0]          hold_code,
  output logic [6:0]          hold_pct
);
  localparam logic [CODE_W-1:0] FIXED_CODE = CODE_W'(4);

  logic wr_fire, expire, low_fire, ps_en, revert, reduce;

  assign wr_ready = !thermal_trip;
  assign wr_fire  = wr_valid && wr_ready;

  generate
    if (FIXED_LEVEL) begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^{cfg_we, cfg_code};
      assign hold_code  = FIXED_CODE;
    end else begin : g_prog
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (cfg_we) code_q <= cfg_code;
      end
      assign hold_code = code_q;
    end
  endgenerate

  assign hold_pct = pct_of(hold_code);
  assign ps_en    = (hold_code != '0) && !thermal_warn;
  assign revert   = !ps_en || low_fire;
  assign reduce   = ps_en && !wr_fire && !low_fire && (expire || ps_force);

  relay_ps_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_fire),
    .cancel  (low_fire || thermal_trip),
    .expire  (expire)
  );

  relay_ps_lowwatch #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_low (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wr_fire),
    .level (ps_force),
    .fire  (low_fire)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    relay_ps_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .wr_bit  (wr_data[i]),
      .trip    (thermal_trip),
      .revert  (revert),
      .reduce  (reduce),
      .mode    (ch_mode[2*i +: 2])
    );
  end
endmodule

// File: rtl/relay_ps_seq_chk.sv
`timescale 1ns/1ps
module relay_ps_seq_chk #(
  parameter int N_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [N_CH-1:0]   wr_data,
  input logic              thermal_warn,
  input logic              thermal_trip,
  input logic [2*N_CH-1:0] ch_mode,
  input logic [2:0]        hold_code
);
  logic [N_CH-1:0] off_m, full_m, hold_m, bad_m;
  logic            fire;

  assign fire = wr_valid && wr_ready;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      off_m[i]  = ch_mode[2*i +: 2] == 2'b00;
      full_m[i] = ch_mode[2*i +: 2] == 2'b01;
      hold_m[i] = ch_mode[2*i +: 2] == 2'b10;
      bad_m[i]  = ch_mode[2*i +: 2] == 2'b11;
    end
  end

  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_m == '0);  // R3
  AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((full_m | hold_m) & ~$past(wr_data)) == '0);  // R4
  AST_NEW_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (full_m & $past(off_m & wr_data)) == $past(off_m & wr_data));  // R5
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !thermal_warn && hold_code != 3'd0)
      |=> (hold_m & $past(hold_m & wr_data)) == $past(hold_m & wr_data));  // R6
  AST_NO_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_code == 3'd0 || thermal_warn) |=> hold_m == '0);  // R10
  AST_TRIP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_trip |=> (full_m | hold_m) == '0);  // R11
endmodule

bind relay_ps_seq relay_ps_seq_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/sim_relay_ps_seq.sv
`timescale 1ns/1ps
module sim_relay_ps_seq;
  localparam int N  = 8;
  localparam int D  = 6;
  localparam int M  = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, cfg_we, ps_force, thermal_warn, thermal_trip;
  logic [N-1:0] wr_data;
  logic [2:0]   cfg_code;
  logic         wr_ready, wr_ready1;
  logic [2*N-1:0] ch_mode, ch_mode1;
  logic [2:0]   hold_code, hold_code1;
  logic [6:0]   hold_pct, hold_pct1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  relay_ps_seq #(.N_CH(N), .DELAY_CYCLES(D), .MIN_LOW_CYCLES(M), .FIXED_LEVEL(1'b0)) u0 (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_data, .cfg_we, .cfg_code, .ps_force,
    .thermal_warn, .thermal_trip, .ch_mode, .hold_code, .hold_pct);

  relay_ps_seq #(.N_CH(N), .DELAY_CYCLES(D), .MIN_LOW_CYCLES(M), .FIXED_LEVEL(1'b1)) u1 (
    .clk, .rst_n, .wr_valid, .wr_ready(wr_ready1), .wr_data, .cfg_we, .cfg_code, .ps_force,
    .thermal_warn, .thermal_trip, .ch_mode(ch_mode1), .hold_code(hold_code1),
    .hold_pct(hold_pct1));

  function automatic logic [2*N-1:0] enc(input logic [N-1:0] full, input logic [N-1:0] hold);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++)
      r[2*i +: 2] = hold[i] ? 2'b10 : (full[i] ? 2'b01 : 2'b00);
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mode(input string req, input logic [2*N-1:0] exp);
    vectors++;
    if (ch_mode !== exp) begin
      miscompares++;
      $display("FAIL %s ch_mode actual=%h expected=%h", req, ch_mode, exp);
    end
  endtask

  task automatic chk_val(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [N-1:0] v);
    wr_valid = 1'b1;
    wr_data  = v;
    tick(1);
    wr_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] c);
    cfg_we   = 1'b1;
    cfg_code = c;
    tick(1);
    cfg_we   = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; cfg_we = 1'b0; cfg_code = '0;
    ps_force = 1'b0; thermal_warn = 1'b0; thermal_trip = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk_mode("R1", '0);
    chk_val("R1 code", int'(hold_code), 0);
    chk_val("R1 pct", int'(hold_pct), 100);
    chk_val("R1 ready", int'(wr_ready), 1);

    // R2 code sweep, both builds
    for (int c = 0; c < 8; c++) begin
      set_cfg(3'(c));
      chk_val("R2 code", int'(hold_code), c);
      chk_val("R2 pct", int'(hold_pct), (c == 0) ? 100 : 20 + 10 * c);
      chk_val("R2 fixed code", int'(hold_code1), 4);
      chk_val("R2 fixed pct", int'(hold_pct1), 60);
    end
    set_cfg(3'd3);

    // R5 / R7 delay edges
    wr(8'hA5);
    chk_mode("R5", enc(8'hA5, 8'h00));
    tick(D - 1);
    chk_mode("R7 before expiry", enc(8'hA5, 8'h00));
    tick(1);
    chk_mode("R7 at expiry", enc(8'h00, 8'hA5));

    // R6 / R4 sticky hold on rewrite
    wr(8'h0F);
    chk_mode("R6 sticky", enc(8'h0A, 8'h05));
    tick(D);
    chk_mode("R7 second", enc(8'h00, 8'h0F));

    // R7 restart
    wr(8'hF0);
    chk_mode("R4 off", enc(8'hF0, 8'h00));
    tick(D - 2);
    wr(8'hF0);
    chk_mode("R6 full stays", enc(8'hF0, 8'h00));
    tick(D - 1);
    chk_mode("R7 restarted", enc(8'hF0, 8'h00));
    tick(1);
    chk_mode("R7 restart expiry", enc(8'h00, 8'hF0));

    // R9 minimum-low window after write
    tick(M - 1 - D);
    chk_mode("R9 before", enc(8'h00, 8'hF0));
    tick(1);
    chk_mode("R9 revert", enc(8'hF0, 8'h00));

    // R8 force, then R9 after it falls
    ps_force = 1'b1;
    tick(1);
    chk_mode("R8 force", enc(8'h00, 8'hF0));
    ps_force = 1'b0;
    tick(M - 1);
    chk_mode("R9 force low before", enc(8'h00, 8'hF0));
    tick(1);
    chk_mode("R9 force low revert", enc(8'hF0, 8'h00));

    // R10 thermal warning
    ps_force = 1'b1;
    tick(1);
    chk_mode("R8 force again", enc(8'h00, 8'hF0));
    thermal_warn = 1'b1;
    tick(1);
    chk_mode("R10 warn revert", enc(8'hF0, 8'h00));
    tick(3);
    chk_mode("R10 warn blocks", enc(8'hF0, 8'h00));
    thermal_warn = 1'b0;
    tick(1);
    chk_mode("R8 after warn", enc(8'h00, 8'hF0));

    // R10 code 000
    set_cfg(3'd0);
    tick(1);
    chk_mode("R10 code0 revert", enc(8'hF0, 8'h00));
    tick(3);
    chk_mode("R10 code0 blocks", enc(8'hF0, 8'h00));
    set_cfg(3'd3);
    tick(1);
    chk_mode("R8 code restored", enc(8'h00, 8'hF0));

    // R11 trip with held write
    ps_force = 1'b0;
    thermal_trip = 1'b1;
    tick(1);
    chk_mode("R11 trip off", '0);
    chk_val("R11 ready", int'(wr_ready), 0);
    wr_valid = 1'b1;
    wr_data  = 8'hFF;
    tick(2);
    chk_mode("R11 write held", '0);
    thermal_trip = 1'b0;
    tick(1);
    wr_valid = 1'b0;
    chk_mode("R11 write lands", enc(8'hFF, 8'h00));

    wr(8'h00);
    chk_mode("R4 all off", '0);

    // R5 / R6 / R8 exhaustive sweep with force held high
    ps_force = 1'b1;
    tick(1);
    prev = '0;
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk_mode("R6 sweep write", enc(8'(v) & ~prev, 8'(v) & prev));
      tick(1);
      chk_mode("R8 sweep idle", enc(8'h00, 8'(v)));
      prev = 8'(v);
    end
    ps_force = 1'b0;
    tick(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule